// File: doc/BRIEF.md
# Wide Modular Multiplier with Resident Modulus

This block computes the product of two wide unsigned integers reduced by a modulus, returning a value between zero and one less than the modulus. The modulus is written once through a dedicated strobe and stays in the block across any number of multiplications. Each multiplication then only needs its two operands and a start pulse. After a fixed number of cycles a one-cycle done pulse marks the reduced result. The caller never sees, and the block never stores, the double-width product.

Internally the block walks the second operand from its top bit to its bottom bit, one bit per clock. On each step the running remainder is doubled and folded back under the modulus. When the current bit is set, the first operand is added and the sum is folded back again. A fold is a single compare-and-subtract, so every intermediate value needs only one bit more than the operand width. The width is a parameter. The default is 128 bits, and widths just above that, such as 131, work without change.

Top module: `wide_modmul`

## Requirements
- R1: After reset, busy_o and done_o are low, result_o is zero and the resident modulus is zero.
- R2: A pulse on load_n_i while busy_o is low stores n_i as the modulus, and that modulus is used by every later multiplication until the next accepted load. A load_n_i pulse while busy_o is high is ignored.
- R3: A start_i pulse while busy_o is low captures a_i and b_i, and busy_o is high from the next cycle. A start_i pulse while busy_o is high is ignored: it does not restart, lengthen or alter the running multiplication.
- R4: For a modulus N of at least 2 and operands A and B both below N, the result is (A*B) mod N, at any width W including 131.
- R5: A first operand A with N <= A < 2N is treated as A-N.
- R6: done_o is high for exactly one cycle. It rises W cycles after the clock edge that accepted start_i, and busy_o falls in that same cycle.
- R7: result_o changes only in a cycle where done_o is high, and it holds its value until the next done pulse.
- R8: When the modulus is 0 or 1, the result delivered with done_o is zero.
- R9: When the modulus is at least 2, the result delivered with done_o is below the modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n_i | input | 1 | Strobe that writes the modulus (taken only while idle) |
| n_i | input | W | Modulus value |
| start_i | input | 1 | Strobe that begins a multiplication (taken only while idle) |
| a_i | input | W | First operand, below twice the modulus |
| b_i | input | W | Second operand, below the modulus |
| busy_o | output | 1 | High while a multiplication is running |
| done_o | output | 1 | One-cycle pulse that marks a new result |
| result_o | output | W | Reduced product, held until the next done pulse |

## Verification
Several properties are checked on every cycle. done_o is a single-cycle pulse that ends a busy period exactly W cycles long, and busy_o follows an accepted start. The modulus does not move while busy_o is high. result_o only changes together with done_o. Every delivered result is below the modulus, or zero for a modulus of 0 or 1.

Other behaviour can only be shown by the bench's scenarios, where results are compared with a wide-integer reference. These scenarios cover the arithmetic itself, the fold of a first operand between N and 2N, operands of zero, N-1 and all ones, a modulus that persists over many operations, and start or load strobes that are ignored while busy.

// File: rtl/wmm_pkg.sv
package wmm_pkg;
    typedef enum logic {
        WMM_IDLE = 1'b0,
        WMM_RUN  = 1'b1
    } wmm_state_e;
endpackage

// File: rtl/mm_condsub.sv
// Single fold: subtract the modulus once when the (W+1)-bit value reaches it.
module mm_condsub #(
    parameter int W = 128
) (
    input  logic [W:0]   val_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] res_o
);
    logic [W:0] mod_ext;
    logic       ge;

    always_comb begin
        mod_ext = {1'b0, mod_i};
        ge      = (val_i >= mod_ext);
        res_o   = ge ? W'(val_i - mod_ext) : val_i[W-1:0];
    end
endmodule

// File: rtl/mm_step.sv
// One bit of the scan: double and fold, then optionally add A and fold.
module mm_step #(
    parameter int W = 128
) (
    input  logic [W-1:0] r_i,
    input  logic [W-1:0] a_i,
    input  logic         bit_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] r_o
);
    logic [W:0]   dbl;
    logic [W-1:0] dbl_red;
    logic [W:0]   sum;
    logic [W-1:0] sum_red;

    assign dbl = {r_i, 1'b0};

    mm_condsub #(.W(W)) u_fold_dbl (
        .val_i (dbl),
        .mod_i (mod_i),
        .res_o (dbl_red)
    );

    assign sum = {1'b0, dbl_red} + {1'b0, a_i};

    mm_condsub #(.W(W)) u_fold_add (
        .val_i (sum),
        .mod_i (mod_i),
        .res_o (sum_red)
    );

    assign r_o = bit_i ? sum_red : dbl_red;
endmodule

// File: rtl/mm_modreg.sv
// Resident modulus register with a flag for the degenerate values 0 and 1.
module mm_modreg #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_val_i,
    output logic [W-1:0] mod_o,
    output logic         tiny_o
);
    logic [W-1:0] mod_d, mod_q;

    always_comb begin
        mod_d = mod_q;
        if (wr_en_i) begin
            mod_d = wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= '0;
        end else begin
            mod_q <= mod_d;
        end
    end

    assign mod_o  = mod_q;
    assign tiny_o = (mod_q <= W'(1));
endmodule

// File: rtl/wide_modmul.sv
module wide_modmul
    import wmm_pkg::*;
#(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n_i,
    input  logic [W-1:0] n_i,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    typedef struct packed {
        wmm_state_e   st;
        logic [CW-1:0] cnt;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] r;
        logic [W-1:0] res;
        logic         done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [W-1:0] n_q;
    logic         n_tiny;
    logic         n_wr;
    logic [W-1:0] a_folded;
    logic [W-1:0] r_next;

    assign n_wr = load_n_i && (ctx_q.st == WMM_IDLE);

    mm_modreg #(.W(W)) u_modreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (n_wr),
        .wr_val_i (n_i),
        .mod_o    (n_q),
        .tiny_o   (n_tiny)
    );

    mm_condsub #(.W(W)) u_fold_a (
        .val_i ({1'b0, a_i}),
        .mod_i (n_q),
        .res_o (a_folded)
    );

    mm_step #(.W(W)) u_step (
        .r_i   (ctx_q.r),
        .a_i   (ctx_q.a),
        .bit_i (ctx_q.b[W-1]),
        .mod_i (n_q),
        .r_o   (r_next)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            WMM_IDLE: begin
                if (start_i) begin
                    ctx_d.st  = WMM_RUN;
                    ctx_d.a   = a_folded;
                    ctx_d.b   = b_i;
                    ctx_d.r   = '0;
                    ctx_d.cnt = LAST_IDX;
                end
            end
            WMM_RUN: begin
                ctx_d.r = r_next;
                ctx_d.b = {ctx_q.b[W-2:0], 1'b0};
                if (ctx_q.cnt == '0) begin
                    ctx_d.st   = WMM_IDLE;
                    ctx_d.done = 1'b1;
                    ctx_d.res  = n_tiny ? '0 : r_next;
                end else begin
                    ctx_d.cnt = ctx_q.cnt - 1'b1;
                end
            end
            default: ctx_d.st = WMM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: WMM_IDLE, cnt: '0, a: '0, b: '0, r: '0, res: '0, done: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy_o   = (ctx_q.st == WMM_RUN);
    assign done_o   = ctx_q.done;
    assign result_o = ctx_q.res;
endmodule

// File: rtl/wmm_check.sv
module wmm_check #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o,
    input logic [W-1:0] n_q
);
    localparam int LW = $clog2(W + 2) + 1;
    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ends_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_run_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_len == LW'(W)));

    p_mod_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(n_q));

    p_result_moves_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    p_tiny_mod_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (n_q <= W'(1))) |-> (result_o == '0));

    p_result_below_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (n_q > W'(1))) |-> (result_o < n_q));
endmodule

bind wide_modmul wmm_check #(.W(W)) u_wmm_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .n_q      (n_q)
);

// File: tb/wide_modmul_test.sv
`timescale 1ns/1ps
module wide_modmul_test;
    localparam int W = 131;
    typedef logic [W-1:0] word_t;
    typedef logic [2*W-1:0] dword_t;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    logic  load_n_i = 1'b0;
    word_t n_i = '0;
    logic  start_i = 1'b0;
    word_t a_i = '0;
    word_t b_i = '0;
    logic  busy_o, done_o;
    word_t result_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    wide_modmul #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_n_i(load_n_i), .n_i(n_i),
        .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not complete, actual cycles %0d expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic word_t ref_mulmod(word_t a, word_t b, word_t n);
        dword_t p;
        if (n <= word_t'(1)) return '0;
        p = dword_t'(a) * dword_t'(b);
        return word_t'(p % dword_t'(n));
    endfunction

    function automatic word_t rand_word();
        logic [159:0] raw;
        raw = {$urandom, $urandom, $urandom, $urandom, $urandom};
        return raw[W-1:0];
    endfunction

    task automatic check(input bit ok, input string tag, input word_t act, input word_t exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_mod(input word_t n);
        @(negedge clk);
        load_n_i = 1'b1;
        n_i = n;
        @(negedge clk);
        load_n_i = 1'b0;
    endtask

    // Runs one multiplication; when disturb is set, strobes start and load mid-run.
    task automatic run_op(input word_t a, input word_t b, input bit disturb,
                          output word_t res, output int lat);
        @(negedge clk);
        start_i = 1'b1;
        a_i = a;
        b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < W + 10) begin
            @(negedge clk);
            lat = lat + 1;
            if (disturb && lat == 3) begin
                start_i = 1'b1;
                a_i = ~a;
                b_i = ~b;
                load_n_i = 1'b1;
                n_i = word_t'(5);
            end else if (disturb && lat == 4) begin
                start_i = 1'b0;
                load_n_i = 1'b0;
            end
        end
        res = result_o;
    endtask

    task automatic op_check(input word_t a, input word_t b, input word_t n,
                            input word_t expv, input string tag);
        word_t res;
        int lat;
        run_op(a, b, 1'b0, res, lat);
        check(res == expv, tag, res, expv);
        check(lat == W, "R6 latency", word_t'(lat), word_t'(W));
    endtask

    initial begin
        word_t n, a, b, res, held;
        int lat;
        void'($urandom(32'd20240607));

        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o, "R1 busy low in reset", word_t'(busy_o), '0);
        check(!done_o, "R1 done low in reset", word_t'(done_o), '0);
        check(result_o == '0, "R1 result zero", result_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R8: modulus resets to zero, so a run without loading yields 0
        op_check(word_t'(9), word_t'(7), '0, '0, "R1 R8 reset modulus gives zero");

        // R4: small directed case
        load_mod(word_t'(7));
        op_check(word_t'(3), word_t'(5), word_t'(7), word_t'(1), "R4 3*5 mod 7");
        // R5: A in [N,2N) folded: 10 -> 3, 3*2 = 6
        op_check(word_t'(10), word_t'(2), word_t'(7), word_t'(6), "R5 A folded once");

        // R4 corners with a full-width modulus of all ones
        n = '1;
        load_mod(n);
        op_check('0, n - 1, n, '0, "R4 zero operand");
        op_check(n - 1, n - 1, n, word_t'(1), "R4 (N-1)^2");
        op_check(n - 1, word_t'(1), n, n - 1, "R4 N-1 times one");
        a = rand_word() % n; b = rand_word() % n;
        op_check(a, b, n, ref_mulmod(a, b, n), "R4 random under all-ones modulus");

        // R8: modulus 1
        load_mod(word_t'(1));
        op_check('0, '0, word_t'(1), '0, "R8 modulus one");

        // R3/R2: start and load while busy are ignored
        n = rand_word() | (word_t'(1) << (W - 1));
        load_mod(n);
        a = rand_word() % n; b = rand_word() % n;
        run_op(a, b, 1'b1, res, lat);
        check(res == ref_mulmod(a, b, n), "R3 start while busy ignored", res, ref_mulmod(a, b, n));
        check(lat == W, "R3 no restart latency", word_t'(lat), word_t'(W));
        a = rand_word() % n; b = rand_word() % n;
        op_check(a, b, n, ref_mulmod(a, b, n), "R2 load while busy ignored");

        // R7: result held after done
        held = result_o;
        repeat (6) @(negedge clk);
        check(result_o == held, "R7 result held", result_o, held);
        check(!done_o, "R6 done is one cycle", word_t'(done_o), '0);

        // R2/R4/R9: modulus persists across many random operations
        for (int i = 0; i < 30; i++) begin
            a = rand_word() % n; b = rand_word() % n;
            run_op(a, b, 1'b0, res, lat);
            check(res == ref_mulmod(a, b, n), "R2 R4 persistent modulus", res, ref_mulmod(a, b, n));
            check(res < n, "R9 result below modulus", res, n);
        end

        // R4: random moduli of varied size, including A between N and 2N (R5)
        for (int k = 0; k < 40; k++) begin
            int sh;
            sh = $urandom_range(W - 2, 0);
            n = (rand_word() >> sh) | word_t'(2);
            load_mod(n);
            a = rand_word() % n; b = rand_word() % n;
            if (k % 4 == 0 && (n >> (W - 1)) == '0) begin
                run_op(a + n, b, 1'b0, res, lat);
                check(res == ref_mulmod(a, b, n), "R5 random A above N", res, ref_mulmod(a, b, n));
            end else begin
                run_op(a, b, 1'b0, res, lat);
                check(res == ref_mulmod(a, b, n), "R4 random modulus", res, ref_mulmod(a, b, n));
            end
            check(lat == W, "R6 latency random", word_t'(lat), word_t'(W));
        end

        // R8: modulus zero after use
        load_mod('0);
        op_check(word_t'(4), word_t'(4), '0, '0, "R8 modulus zero");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule